// File: doc/BRIEF.md
# Pixel Raster Operation Unit

This unit merges a source pixel with the destination pixel fetched from a frame buffer and returns the pixel to store back, plus a write-enable for that store. The combining rule is a 5-bit operation code held in a control register field. Sixteen codes cover every Boolean function of two bits. Further codes give wrapping and saturating addition and subtraction, and maximum and minimum selection. All unused codes act as a plain replace.

The programmed pixel size (1, 2, 4, 8 or 16 bits) bounds every operation. Operand bits above the pixel width are ignored. Saturation clamps to the all-ones value of that width. The result carries zeros above it. A plane mask protects chosen bit planes, which keep their destination value. An optional transparency mode withholds the write when the final pixel is zero. The caller presents operands with a one-cycle strobe and gets a registered result one clock later. Addressing, word packing and fetches are handled outside the unit.

Top module: `pixel_rop_unit`

## Requirements
- R1: The operation code is `ctrl_reg[14:10]`. Codes 0..15 apply a Boolean function bit by bit: 0 S, 1 S&D, 2 S&~D, 3 all zeros, 4 S|~D, 5 ~(S^D), 6 ~D, 7 ~(S|D), 8 S|D, 9 D, 10 S^D, 11 ~S&D, 12 all ones, 13 ~S|D, 14 ~(S&D), 15 ~S.
- R2: Code 16 gives S+D modulo 2^W. Code 17 gives S+D clamped to 2^W-1. W is the effective pixel width.
- R3: Code 18 gives D-S modulo 2^W. Code 19 gives D-S, or zero when S is greater than D.
- R4: Code 20 gives the larger of S and D, and code 21 gives the smaller, both compared as unsigned values.
- R5: Codes 22 through 31 give S, the same as code 0.
- R6: `psize_reg` values 1, 2, 4, 8 and 16 set W to that value; any other value sets W to 1. Bits of S and D at or above W do not affect the result, and `out_pix` bits at or above W are zero.
- R7: Each `plane_mask` bit that is 1 makes the matching result bit equal the destination bit. Each mask bit that is 0 leaves the operation result in place.
- R8: When `ctrl_reg[5]` is 1 and the final pixel is zero, `out_we` is 0. Otherwise `out_we` is 1 for every accepted strobe.
- R9: A strobe on `in_valid` yields `out_valid`, `out_pix` and `out_we` on the next clock. A cycle without a strobe gives `out_valid`=0 and `out_we`=0 on the next clock, and `out_pix` holds its value.
- R10: While `rst_n` is low, `out_valid` and `out_we` are 0 and `out_pix` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand strobe, one cycle per pixel |
| src_pix | input | 16 | Source pixel S |
| dst_pix | input | 16 | Destination pixel D read from the frame buffer |
| ctrl_reg | input | 16 | Control word: bits 14:10 operation code, bit 5 transparency enable |
| psize_reg | input | 16 | Pixel size in bits |
| plane_mask | input | 16 | Bits set to 1 keep the destination value |
| out_valid | output | 1 | Result valid, one clock after the strobe |
| out_pix | output | 16 | Pixel to write back |
| out_we | output | 1 | Write-enable for the result pixel |

## Verification
The bound checker watches, on every clock, several properties:
- the one-clock strobe-to-valid relation and the hold of the pixel on idle cycles;
- the zeros above the effective width;
- the protection of masked planes;
- the write-enable rule for both transparency settings.

Only the bench scenarios can show that each of the 32 codes computes the right value. The same holds for saturation clamping at each width, for the fallback of illegal size values to one bit, and for operand bits above the width being ignored. The bench covers these by comparing every output against a model written from the requirements.

// File: rtl/rop_pkg.sv
package rop_pkg;

  localparam int unsigned OPC_W      = 5;
  localparam int unsigned OPC_LSB    = 10;
  localparam int unsigned TRANSP_BIT = 5;

  typedef enum logic [OPC_W-1:0] {
    ROP_COPY     = 5'd0,
    ROP_AND      = 5'd1,
    ROP_AND_ND   = 5'd2,
    ROP_ZERO     = 5'd3,
    ROP_OR_ND    = 5'd4,
    ROP_XNOR     = 5'd5,
    ROP_NOT_D    = 5'd6,
    ROP_NOR      = 5'd7,
    ROP_OR       = 5'd8,
    ROP_KEEP     = 5'd9,
    ROP_XOR      = 5'd10,
    ROP_NS_AND   = 5'd11,
    ROP_ONES     = 5'd12,
    ROP_NS_OR    = 5'd13,
    ROP_NAND     = 5'd14,
    ROP_NOT_S    = 5'd15,
    ROP_ADD      = 5'd16,
    ROP_ADD_SAT  = 5'd17,
    ROP_SUB      = 5'd18,
    ROP_SUB_SAT  = 5'd19,
    ROP_MAX      = 5'd20,
    ROP_MIN      = 5'd21
  } rop_code_e;

  // Truth table per Boolean code; index is {s_bit, d_bit}.
  function automatic logic [3:0] bool_table(input logic [3:0] code);
    logic [3:0] t;
    case (code)
      4'd0:    t = 4'b1100;
      4'd1:    t = 4'b1000;
      4'd2:    t = 4'b0100;
      4'd3:    t = 4'b0000;
      4'd4:    t = 4'b1101;
      4'd5:    t = 4'b1001;
      4'd6:    t = 4'b0101;
      4'd7:    t = 4'b0001;
      4'd8:    t = 4'b1110;
      4'd9:    t = 4'b1010;
      4'd10:   t = 4'b0110;
      4'd11:   t = 4'b0010;
      4'd12:   t = 4'b1111;
      4'd13:   t = 4'b1011;
      4'd14:   t = 4'b0111;
      default: t = 4'b0011;
    endcase
    return t;
  endfunction

endpackage

// File: rtl/rop_width_dec.sv
module rop_width_dec #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned PSZ_W  = 16
) (
  input  logic [PSZ_W-1:0]  psize,
  output logic [DATA_W-1:0] wmask
);

  localparam int unsigned NSZ = $clog2(DATA_W) + 1;

  logic [NSZ-1:0]    hit;
  logic [DATA_W-1:0] cand [NSZ];

  generate
    for (genvar k = 0; k < NSZ; k++) begin : g_size
      localparam int unsigned BITS = 1 << k;
      assign hit[k]  = (psize == PSZ_W'(BITS));
      assign cand[k] = {DATA_W{1'b1}} >> (DATA_W - BITS);
    end
  endgenerate

  // Size 1 is the fallback for every unlisted value.
  always_comb begin
    wmask = cand[0];
    for (int k = 1; k < NSZ; k++) begin
      if (hit[k]) wmask = cand[k];
    end
  end

endmodule

// File: rtl/rop_alu.sv
module rop_alu
  import rop_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic [DATA_W-1:0] src,
  input  logic [DATA_W-1:0] dst,
  input  rop_code_e         opcode,
  input  logic [DATA_W-1:0] wmask,
  output logic [DATA_W-1:0] res
);

  logic [DATA_W-1:0] s_m, d_m;
  logic [DATA_W:0]   sum, dif;
  logic [3:0]        tt;
  logic [DATA_W-1:0] bool_res;
  logic [DATA_W-1:0] raw;
  logic              add_ovf;

  assign s_m = src & wmask;
  assign d_m = dst & wmask;
  assign sum = {1'b0, s_m} + {1'b0, d_m};
  assign dif = {1'b0, d_m} - {1'b0, s_m};
  assign tt  = bool_table(opcode[3:0]);
  assign add_ovf = sum[DATA_W] | (|(sum[DATA_W-1:0] & ~wmask));

  generate
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      assign bool_res[i] = tt[{s_m[i], d_m[i]}];
    end
  endgenerate

  always_comb begin
    case (opcode)
      ROP_ADD:     raw = sum[DATA_W-1:0];
      ROP_ADD_SAT: raw = add_ovf ? wmask : sum[DATA_W-1:0];
      ROP_SUB:     raw = dif[DATA_W-1:0];
      ROP_SUB_SAT: raw = dif[DATA_W] ? '0 : dif[DATA_W-1:0];
      ROP_MAX:     raw = (s_m > d_m) ? s_m : d_m;
      ROP_MIN:     raw = (s_m > d_m) ? d_m : s_m;
      default:     raw = opcode[4] ? s_m : bool_res;
    endcase
  end

  assign res = raw & wmask;

endmodule

// File: rtl/rop_write_qual.sv
module rop_write_qual #(
  parameter int unsigned DATA_W = 16
) (
  input  logic [DATA_W-1:0] alu_res,
  input  logic [DATA_W-1:0] dst,
  input  logic [DATA_W-1:0] plane_mask,
  input  logic [DATA_W-1:0] wmask,
  input  logic              transp_en,
  output logic [DATA_W-1:0] pix,
  output logic              we
);

  assign pix = ((alu_res & ~plane_mask) | (dst & plane_mask)) & wmask;
  assign we  = !(transp_en && (pix == '0));

endmodule

// File: rtl/pixel_rop_unit.sv
module pixel_rop_unit
  import rop_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CTRL_W = 16,
  parameter int unsigned PSZ_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] src_pix,
  input  logic [DATA_W-1:0] dst_pix,
  input  logic [CTRL_W-1:0] ctrl_reg,
  input  logic [PSZ_W-1:0]  psize_reg,
  input  logic [DATA_W-1:0] plane_mask,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_pix,
  output logic              out_we
);

  localparam int unsigned OPC_HI = OPC_LSB + OPC_W - 1;

  rop_code_e         opcode;
  logic              transp_en;
  logic [DATA_W-1:0] wmask;
  logic [DATA_W-1:0] alu_res;
  logic [DATA_W-1:0] qual_pix;
  logic              qual_we;

  logic              vld_q, vld_d;
  logic [DATA_W-1:0] pix_q, pix_d;
  logic              we_q,  we_d;

  assign opcode    = rop_code_e'(ctrl_reg[OPC_HI:OPC_LSB]);
  assign transp_en = ctrl_reg[TRANSP_BIT];

  rop_width_dec #(.DATA_W(DATA_W), .PSZ_W(PSZ_W)) i_width (
    .psize (psize_reg),
    .wmask (wmask)
  );

  rop_alu #(.DATA_W(DATA_W)) i_alu (
    .src    (src_pix),
    .dst    (dst_pix),
    .opcode (opcode),
    .wmask  (wmask),
    .res    (alu_res)
  );

  rop_write_qual #(.DATA_W(DATA_W)) i_qual (
    .alu_res    (alu_res),
    .dst        (dst_pix),
    .plane_mask (plane_mask),
    .wmask      (wmask),
    .transp_en  (transp_en),
    .pix        (qual_pix),
    .we         (qual_we)
  );

  always_comb begin
    vld_d = in_valid;
    pix_d = pix_q;
    we_d  = 1'b0;
    if (in_valid) begin
      pix_d = qual_pix;
      we_d  = qual_we;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      pix_q <= '0;
      we_q  <= 1'b0;
    end else begin
      vld_q <= vld_d;
      pix_q <= pix_d;
      we_q  <= we_d;
    end
  end

  assign out_valid = vld_q;
  assign out_pix   = pix_q;
  assign out_we    = we_q;

endmodule

// File: rtl/pixel_rop_unit_chk.sv
module pixel_rop_unit_chk #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CTRL_W = 16,
  parameter int unsigned PSZ_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [DATA_W-1:0] dst_pix,
  input logic [CTRL_W-1:0] ctrl_reg,
  input logic [PSZ_W-1:0]  psize_reg,
  input logic [DATA_W-1:0] plane_mask,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_pix,
  input logic              out_we
);

  logic [DATA_W-1:0] wm_now;

  always_comb begin
    wm_now = {{(DATA_W-1){1'b0}}, 1'b1};
    for (int w = 2; w <= DATA_W; w = w * 2) begin
      if (psize_reg == PSZ_W'(w)) wm_now = DATA_W'((64'd1 << w) - 64'd1);
    end
  end

  // R9
  strobe_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !out_we && $stable(out_pix)));

  // R6
  above_width_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ((out_pix & ~$past(wm_now)) == '0));

  // R7
  plane_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (((out_pix ^ $past(dst_pix)) & $past(plane_mask) & $past(wm_now)) == '0));

  // R8
  opaque_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !ctrl_reg[5]) |=> out_we);

  // R8
  transp_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ctrl_reg[5]) |=> (out_we == (out_pix != '0)));

  // R9
  we_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_we |-> out_valid);

endmodule

bind pixel_rop_unit pixel_rop_unit_chk #(
  .DATA_W (DATA_W),
  .CTRL_W (CTRL_W),
  .PSZ_W  (PSZ_W)
) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .dst_pix    (dst_pix),
  .ctrl_reg   (ctrl_reg),
  .psize_reg  (psize_reg),
  .plane_mask (plane_mask),
  .out_valid  (out_valid),
  .out_pix    (out_pix),
  .out_we     (out_we)
);

// File: tb/test_pixel_rop_unit.sv
module test_pixel_rop_unit;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [15:0] src_pix, dst_pix, ctrl_reg, psize_reg, plane_mask;
  logic        out_valid;
  logic [15:0] out_pix;
  logic        out_we;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  typedef struct {
    bit          v;
    logic [15:0] pix;
    bit          we;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  logic [15:0] last_pix = 16'h0;

  pixel_rop_unit i_pixel_rop_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .src_pix(src_pix), .dst_pix(dst_pix), .ctrl_reg(ctrl_reg),
    .psize_reg(psize_reg), .plane_mask(plane_mask),
    .out_valid(out_valid), .out_pix(out_pix), .out_we(out_we)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [15:0] mk_ctrl(input int code, input bit tr);
    return {1'b0, 5'(code), 4'b0000, tr, 5'b00000};
  endfunction

  function automatic string req_of(input int code);
    if (code < 16) return "R1";
    if (code < 18) return "R2";
    if (code < 20) return "R3";
    if (code < 22) return "R4";
    return "R5";
  endfunction

  function automatic logic [15:0] model(input logic [15:0] s, input logic [15:0] d,
                                        input logic [15:0] c, input logic [15:0] p,
                                        input logic [15:0] pm);
    int w;
    int unsigned m, S, D, r;
    case (p)
      16'd2: w = 2; 16'd4: w = 4; 16'd8: w = 8; 16'd16: w = 16;
      default: w = 1;
    endcase
    m = (32'd1 << w) - 1;
    S = 32'(s) & m;
    D = 32'(d) & m;
    case (int'(c[14:10]))
      0: r = S;            1: r = S & D;          2: r = S & ~D;
      3: r = 0;            4: r = S | ~D;         5: r = ~(S ^ D);
      6: r = ~D;           7: r = ~(S | D);       8: r = S | D;
      9: r = D;            10: r = S ^ D;         11: r = ~S & D;
      12: r = 32'hFFFF_FFFF; 13: r = ~S | D;      14: r = ~(S & D);
      15: r = ~S;          16: r = S + D;
      17: r = (S + D > m) ? m : S + D;
      18: r = D - S;
      19: r = (S > D) ? 0 : D - S;
      20: r = (S > D) ? S : D;
      21: r = (S > D) ? D : S;
      default: r = S;
    endcase
    r = r & m;
    r = ((r & ~32'(pm)) | (D & 32'(pm))) & m;
    return r[15:0];
  endfunction

  task automatic drive(input bit v, input logic [15:0] s, input logic [15:0] d,
                       input logic [15:0] c, input logic [15:0] p,
                       input logic [15:0] pm, input string tag);
    exp_t e;
    @(negedge clk);
    in_valid = v; src_pix = s; dst_pix = d; ctrl_reg = c;
    psize_reg = p; plane_mask = pm;
    e.v   = v;
    e.pix = model(s, d, c, p, pm);
    e.we  = v && !(c[5] && e.pix == 16'h0);
    e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic idle(input string tag);
    drive(1'b0, 16'hDEAD, 16'hBEEF, mk_ctrl(12, 1'b0), 16'd8, 16'h0, tag);
  endtask

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (rst_n && sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      if (e.v) begin
        chk(out_valid == 1'b1, e.tag, "out_valid", int'(out_valid), 1);
        chk(out_pix == e.pix, e.tag, "out_pix", int'(out_pix), int'(e.pix));
        chk(out_we == e.we, e.tag, "out_we", int'(out_we), int'(e.we));
        last_pix = e.pix;
      end else begin
        // R9 idle cycle: no valid, no write, pixel held
        chk(out_valid == 1'b0, "R9", "idle out_valid", int'(out_valid), 0);
        chk(out_we == 1'b0, "R9", "idle out_we", int'(out_we), 0);
        chk(out_pix == last_pix, "R9", "held out_pix", int'(out_pix), int'(last_pix));
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    logic [15:0] sv [4];
    logic [15:0] dv [4];
    sv[0] = 16'h00C5; dv[0] = 16'h003A;
    sv[1] = 16'h00F0; dv[1] = 16'h0020;
    sv[2] = 16'h0010; dv[2] = 16'h0080;
    sv[3] = 16'h00FF; dv[3] = 16'h00FF;

    rst_n = 1'b0; in_valid = 1'b0; src_pix = '0; dst_pix = '0;
    ctrl_reg = '0; psize_reg = 16'd8; plane_mask = '0;
    repeat (3) @(posedge clk);
    #1;
    // R10 reset state
    chk(out_valid == 1'b0, "R10", "reset out_valid", int'(out_valid), 0);
    chk(out_we == 1'b0, "R10", "reset out_we", int'(out_we), 0);
    chk(out_pix == 16'h0, "R10", "reset out_pix", int'(out_pix), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 R2 R3 R4 R5: every code at 8-bit pixels, with upper garbage bits
    for (int code = 0; code < 32; code++) begin
      for (int k = 0; k < 4; k++) begin
        drive(1'b1, sv[k] | 16'hA500, dv[k] | 16'h5A00, mk_ctrl(code, 1'b0),
              16'd8, 16'h0, req_of(code));
      end
    end

    // R6 R2 R3 saturation and wrap across every legal width
    for (int p = 1; p <= 16; p = p * 2) begin
      drive(1'b1, 16'hFFFF, 16'h0001, mk_ctrl(16, 1'b0), 16'(p), 16'h0, "R2");
      drive(1'b1, 16'hFFFF, 16'h0001, mk_ctrl(17, 1'b0), 16'(p), 16'h0, "R2");
      drive(1'b1, 16'h0003, 16'h0001, mk_ctrl(18, 1'b0), 16'(p), 16'h0, "R3");
      drive(1'b1, 16'h0003, 16'h0001, mk_ctrl(19, 1'b0), 16'(p), 16'h0, "R3");
      drive(1'b1, 16'h1234, 16'hFEDC, mk_ctrl(12, 1'b0), 16'(p), 16'h0, "R6");
    end
    // R2 saturation at 16-bit: 0x8000+0x8000 clamps to 0xFFFF
    drive(1'b1, 16'h8000, 16'h8000, mk_ctrl(17, 1'b0), 16'd16, 16'h0, "R2");
    // R4 unsigned compare at 16-bit
    drive(1'b1, 16'h8001, 16'h7FFF, mk_ctrl(20, 1'b0), 16'd16, 16'h0, "R4");
    drive(1'b1, 16'h8001, 16'h7FFF, mk_ctrl(21, 1'b0), 16'd16, 16'h0, "R4");

    // R6 illegal sizes fall back to one bit
    drive(1'b1, 16'h00FF, 16'h0000, mk_ctrl(0, 1'b0), 16'd3, 16'h0, "R6");
    drive(1'b1, 16'h00FF, 16'h0000, mk_ctrl(0, 1'b0), 16'd0, 16'h0, "R6");
    drive(1'b1, 16'h0001, 16'h0001, mk_ctrl(17, 1'b0), 16'd32, 16'h0, "R6");
    drive(1'b1, 16'h00FE, 16'h0000, mk_ctrl(12, 1'b0), 16'd7, 16'h0, "R6");

    // R7 plane mask
    drive(1'b1, 16'hFFFF, 16'h0000, mk_ctrl(0, 1'b0), 16'd16, 16'h00F0, "R7");
    drive(1'b1, 16'h0000, 16'hFFFF, mk_ctrl(3, 1'b0), 16'd16, 16'hAAAA, "R7");
    drive(1'b1, 16'h1234, 16'h5678, mk_ctrl(16, 1'b0), 16'd8, 16'hFFFF, "R7");

    // R8 transparency
    drive(1'b1, 16'h0055, 16'h0077, mk_ctrl(3, 1'b1), 16'd8, 16'h0, "R8");
    drive(1'b1, 16'h0055, 16'h0077, mk_ctrl(12, 1'b1), 16'd8, 16'h0, "R8");
    drive(1'b1, 16'h0042, 16'h0042, mk_ctrl(18, 1'b1), 16'd8, 16'h0, "R8");
    drive(1'b1, 16'h0042, 16'h0042, mk_ctrl(18, 1'b0), 16'd8, 16'h0, "R8");
    drive(1'b1, 16'h0000, 16'h0001, mk_ctrl(0, 1'b1), 16'd1, 16'h0001, "R8");

    // R9 idle gaps hold the pixel
    drive(1'b1, 16'h00A5, 16'h0000, mk_ctrl(0, 1'b0), 16'd8, 16'h0, "R9");
    idle("R9");
    idle("R9");
    drive(1'b1, 16'h005A, 16'h0000, mk_ctrl(0, 1'b0), 16'd8, 16'h0, "R9");
    idle("R9");

    // mixed random traffic
    for (int n = 0; n < 300; n++) begin
      int unsigned r;
      int code;
      r = $urandom;
      code = int'(r[4:0]);
      drive(r[20] | r[21], 16'($urandom), 16'($urandom), mk_ctrl(code, r[8]),
            16'(1 << (r[11:9] % 5)), (r[12] ? 16'($urandom) : 16'h0), req_of(code));
    end

    idle("R9");
    idle("R9");
    repeat (3) @(posedge clk);
    #3;
    finish_run();
  end

endmodule